// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates a set of edge-triggered interrupt lines, each carrying a 4-bit priority, against a 5-bit processor level. A rising edge on a line marks it pending. A pending line may be taken when its priority is greater than or equal to the current level. When a line is taken, the block sends a one-cycle take pulse with the line's vector index and raises the level to that priority plus one. It also pushes the previous level, together with the vector being entered, onto an internal return stack.

A return pulse pops that stack. It restores the saved level and reports the vector of the service being left, so nested services always unwind in the right order. A separate exception input is taken at any level. Exceptions use a vector index one above the last line and do not change the level.

Because the level is one bit wider than a priority, taking a priority-15 line gives level 16. At that level every line is masked, but requests keep their pending bits until software lowers the level. Software can write the level directly and read it back at any time.

A three-state service machine follows the controller's context:
- `ST_IDLE`: the stack is empty and the level is below 16.
- `ST_NESTED`: the stack holds entries and the level is below 16.
- `ST_MASKED`: the level is 16 or more.

Its named transitions are:
- `T_ENTER`: `ST_IDLE` to `ST_NESTED`.
- `T_SATURATE`: any state to `ST_MASKED`.
- `T_UNWIND`: `ST_NESTED` to `ST_IDLE`.
- `T_RELEASE`: `ST_MASKED` to `ST_NESTED` or `ST_IDLE`.

Line acceptance is allowed only outside `ST_MASKED`.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset the level reads 0, no line or exception is pending, the stack is empty, and `take_vld` and `ret_vld` are low.
- R2: A rising edge on a line driven before clock edge A marks it pending at A. If the line is eligible (priority >= level), `take_vld` is high with `take_vec` equal to the line index after clock edge A+1.
- R3: When a line is taken, the level becomes its priority plus one, visible on `lvl_rd` in the same cycle as `take_vld`.
- R4: Among eligible pending lines the highest priority is taken first. Equal priorities go to the lowest line index.
- R5: A pending line below the level is never dropped. It is taken once a level write or a return brings the level down to its priority or lower.
- R6: Taking a priority-15 line sets the level to 16. No line is taken while the level is 16 or more.
- R7: An exception pulse is taken at any level with `take_vec` = 16 and the level unchanged. A pending exception is taken before any pending line.
- R8: A return pulse with a non-empty stack gives `ret_vld` in the next cycle, with `ret_vec` equal to the most recently entered vector. `lvl_rd` shows the level that was saved on entry (last-in first-out).
- R9: A return pulse with an empty stack is ignored: no `ret_vld`, and the level is unchanged.
- R10: A level write sets `lvl_rd` at the next edge and overrides a same-cycle restore. No take happens in a cycle that has a write or a return pulse.
- R11: The taken line's pending bit is cleared on acceptance. A held-high line is not taken again. A new rising edge during its service marks it pending again.
- R12: The stack holds 17 entries. When it is full, nothing is taken and requests stay pending until a return frees an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 16 | Interrupt lines, rising edge requests service |
| irq_prio | input | 64 | Priority of line i in bits [4i+3:4i] |
| exc_req | input | 1 | Exception request pulse, not masked by level |
| ret_pulse | input | 1 | Return-from-service pulse |
| lvl_wr_en | input | 1 | Software level write strobe |
| lvl_wr_data | input | 5 | Level value to write |
| lvl_rd | output | 5 | Current processor level |
| take_vld | output | 1 | One-cycle pulse: a vector is taken |
| take_vec | output | 5 | Taken vector (0..15 lines, 16 exception) |
| ret_vld | output | 1 | One-cycle pulse: a service was unwound |
| ret_vec | output | 5 | Vector of the service being returned from |

## Verification
A corrupted level register shows up on `lvl_rd` in the cycle it happens. It also shows up within two edges of the next request, as a line taken when it should be masked, or held when it should be taken. A wrong stack entry stays hidden until the matching return, and then appears as a wrong `ret_vec` or a wrong restored level. The bench therefore always unwinds nested services and checks every pop. A lost pending bit only appears when the level later drops, so each masked-request test lowers the level and waits for the deferred take.

// File: rtl/nic_pkg.sv
`timescale 1ns/1ps
package nic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NESTED = 2'd1,
        ST_MASKED = 2'd2
    } svc_state_e;

    typedef enum logic [1:0] {
        TK_NONE = 2'd0,
        TK_EXC  = 2'd1,
        TK_IRQ  = 2'd2
    } take_kind_e;
endpackage

// File: rtl/nic_pending.sv
`timescale 1ns/1ps
module nic_pending #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] irq_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] rise;

    assign rise = irq_in & ~irq_q;
    assign pend = pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= '0;
            pend_q <= '0;
        end else begin
            irq_q  <= irq_in;
            pend_q <= (pend_q & ~clr) | rise;
        end
    end

    // R5: a pending bit only disappears through an acceptance clear
    p_pending_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(pend_q) & ~$past(clr)) & ~pend_q) == '0));

    // R11: a cleared bit without a fresh edge is gone next cycle
    p_clear_takes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(clr) & ~$past(rise)) & pend_q) == '0));
endmodule

// File: rtl/nic_arbiter.sv
`timescale 1ns/1ps
module nic_arbiter #(
    parameter int N  = 16,
    parameter int PW = 4,
    parameter int LW = PW + 1,
    parameter int IW = 5
) (
    input  logic [N-1:0]    pend,
    input  logic [N*PW-1:0] prio_flat,
    input  logic [LW-1:0]   level,
    output logic            hit,
    output logic [IW-1:0]   win_idx,
    output logic [PW-1:0]   win_prio
);
    logic [PW-1:0] prio_arr [N];
    logic [N-1:0]  elig;

    for (genvar g = 0; g < N; g++) begin : g_line
        assign prio_arr[g] = prio_flat[g*PW +: PW];
        assign elig[g]     = pend[g] && ({1'b0, prio_arr[g]} >= level);
    end

    // upward scan with strict compare keeps the lowest index on ties
    always_comb begin
        hit      = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!hit || prio_arr[i] > win_prio)) begin
                hit      = 1'b1;
                win_idx  = IW'(i);
                win_prio = prio_arr[i];
            end
        end
    end
endmodule

// File: rtl/nic_stack.sv
`timescale 1ns/1ps
module nic_stack #(
    parameter int DEPTH = 17,
    parameter int W     = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  top,
    output logic          empty,
    output logic          full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] top_idx;

    assign count   = cnt_q;
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign top_idx = AW'(cnt_q - CW'(1));
    assign top     = empty ? '0 : mem[top_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (pop) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[AW'(cnt_q)] <= din;
        end
    end

    p_depth_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    p_no_overfill_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));
    p_push_pop_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/nested_irq_ctrl.sv
`timescale 1ns/1ps
module nested_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int PRIO_W      = 4,
    parameter int STACK_DEPTH = 17
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        irq_in,
    input  logic [NUM_LINES*PRIO_W-1:0] irq_prio,
    input  logic                        exc_req,
    input  logic                        ret_pulse,
    input  logic                        lvl_wr_en,
    input  logic [PRIO_W:0]             lvl_wr_data,
    output logic [PRIO_W:0]             lvl_rd,
    output logic                        take_vld,
    output logic [$clog2(NUM_LINES+1)-1:0] take_vec,
    output logic                        ret_vld,
    output logic [$clog2(NUM_LINES+1)-1:0] ret_vec
);
    localparam int LVL_W   = PRIO_W + 1;
    localparam int VEC_W   = $clog2(NUM_LINES + 1);
    localparam int ENT_W   = LVL_W + VEC_W;
    localparam int CNT_W   = $clog2(STACK_DEPTH + 1);
    localparam logic [VEC_W-1:0] EXC_VEC = VEC_W'(NUM_LINES);
    localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(1 << PRIO_W);

    svc_state_e state_q, state_d;
    take_kind_e kind;

    logic [LVL_W-1:0]     level_q, level_d;
    logic                 exc_pend_q;
    logic [NUM_LINES-1:0] pend, clr;
    logic                 hit;
    logic [VEC_W-1:0]     win_idx;
    logic [PRIO_W-1:0]    win_prio;
    logic                 push, pop, stk_empty, stk_full;
    logic [ENT_W-1:0]     push_ent, top_ent;
    logic [CNT_W-1:0]     stk_count;
    logic                 nonempty_d, masked_d, cmd_cycle;
    logic [VEC_W-1:0]     enter_vec;

    nic_pending #(.N(NUM_LINES)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .clr    (clr),
        .pend   (pend)
    );

    nic_arbiter #(.N(NUM_LINES), .PW(PRIO_W), .LW(LVL_W), .IW(VEC_W)) u_arbiter (
        .pend      (pend),
        .prio_flat (irq_prio),
        .level     (level_q),
        .hit       (hit),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    nic_stack #(.DEPTH(STACK_DEPTH), .W(ENT_W)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (push_ent),
        .top   (top_ent),
        .empty (stk_empty),
        .full  (stk_full),
        .count (stk_count)
    );

    // ---------------- decision ----------------
    assign cmd_cycle = ret_pulse || lvl_wr_en;

    always_comb begin
        kind = TK_NONE;
        if (!cmd_cycle && !stk_full) begin
            if (exc_pend_q) begin
                kind = TK_EXC;
            end else if (hit && state_q != ST_MASKED) begin
                kind = TK_IRQ;
            end
        end
    end

    assign pop       = ret_pulse && !stk_empty;
    assign push      = (kind != TK_NONE);
    assign enter_vec = (kind == TK_EXC) ? EXC_VEC : win_idx;
    assign push_ent  = {level_q, enter_vec};
    assign clr       = (kind == TK_IRQ) ? (NUM_LINES'(1) << win_idx) : '0;

    always_comb begin
        level_d = level_q;
        if (lvl_wr_en) begin
            level_d = lvl_wr_data;
        end else if (pop) begin
            level_d = top_ent[ENT_W-1 -: LVL_W];
        end else if (kind == TK_IRQ) begin
            level_d = LVL_W'(win_prio) + LVL_W'(1);
        end
    end

    assign masked_d   = (level_d >= LVL_TOP);
    assign nonempty_d = push || (pop ? (stk_count > CNT_W'(1)) : !stk_empty);

    // ---------------- service state machine ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (masked_d)        state_d = ST_MASKED;   // T_SATURATE
                else if (nonempty_d) state_d = ST_NESTED;   // T_ENTER
            end
            ST_NESTED: begin
                if (masked_d)         state_d = ST_MASKED;  // T_SATURATE
                else if (!nonempty_d) state_d = ST_IDLE;    // T_UNWIND
            end
            ST_MASKED: begin
                if (!masked_d) begin                        // T_RELEASE
                    state_d = nonempty_d ? ST_NESTED : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            level_q    <= '0;
            exc_pend_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            level_q    <= level_d;
            exc_pend_q <= (exc_pend_q && kind != TK_EXC) || exc_req;
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_vld <= 1'b0;
            take_vec <= '0;
            ret_vld  <= 1'b0;
            ret_vec  <= '0;
        end else begin
            take_vld <= push;
            take_vec <= push ? enter_vec : '0;
            ret_vld  <= pop;
            ret_vec  <= pop ? top_ent[VEC_W-1:0] : '0;
        end
    end

    assign lvl_rd = level_q;

    // ---------------- assertions ----------------
    function automatic logic [PRIO_W-1:0] prio_of(
        input logic [NUM_LINES*PRIO_W-1:0] v,
        input logic [VEC_W-1:0]            idx
    );
        return v[int'(idx)*PRIO_W +: PRIO_W];
    endfunction

    p_take_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vld && take_vec != EXC_VEC) |->
            (LVL_W'(prio_of($past(irq_prio), take_vec)) >= $past(lvl_rd)));

    p_level_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vld && take_vec != EXC_VEC) |->
            (lvl_rd == LVL_W'(prio_of($past(irq_prio), take_vec)) + LVL_W'(1)));

    p_masked_no_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_rd >= LVL_TOP) |=> !(take_vld && take_vec != EXC_VEC));

    p_exc_keeps_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vld && take_vec == EXC_VEC) |-> (lvl_rd == $past(lvl_rd)));

    p_ret_needs_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld |-> ($past(stk_count) != '0));

    p_single_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_vld, ret_vld}));
endmodule

// File: tb/nested_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nested_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq;
    logic [63:0] prio;
    logic        exc_req, ret_pulse, lvl_wr_en;
    logic [4:0]  lvl_wr_data;
    logic [4:0]  lvl_rd;
    logic        take_vld, ret_vld;
    logic [4:0]  take_vec, ret_vec;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    nested_irq_ctrl u_nested_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq),
        .irq_prio    (prio),
        .exc_req     (exc_req),
        .ret_pulse   (ret_pulse),
        .lvl_wr_en   (lvl_wr_en),
        .lvl_wr_data (lvl_wr_data),
        .lvl_rd      (lvl_rd),
        .take_vld    (take_vld),
        .take_vec    (take_vec),
        .ret_vld     (ret_vld),
        .ret_vec     (ret_vec)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq = '0; prio = '0; exc_req = 0; ret_pulse = 0;
        lvl_wr_en = 0; lvl_wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_prio(input int line, input int p);
        prio[line*4 +: 4] = 4'(p);
    endtask

    task automatic raise(input int line);
        @(negedge clk); irq[line] = 1'b1;
    endtask

    task automatic drop(input int line);
        @(negedge clk); irq[line] = 1'b0;
    endtask

    task automatic pulse_exc();
        @(negedge clk); exc_req = 1'b1;
        @(negedge clk); exc_req = 1'b0;
    endtask

    task automatic do_ret();
        @(negedge clk); ret_pulse = 1'b1;
        @(negedge clk); ret_pulse = 1'b0;
    endtask

    task automatic do_write(input int v);
        @(negedge clk); lvl_wr_en = 1'b1; lvl_wr_data = 5'(v);
        @(negedge clk); lvl_wr_en = 1'b0;
    endtask

    task automatic expect_take(input string tag, input int vec, input int lvl);
        bit got = 0;
        int v = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (take_vld) begin got = 1; v = int'(take_vec); break; end
        end
        chk(got && v == vec, {tag, " take_vec"}, got ? v : -1, vec);
        chk(int'(lvl_rd) == lvl, {tag, " level"}, int'(lvl_rd), lvl);
    endtask

    task automatic expect_quiet(input string tag, input int cycles);
        bit seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (take_vld) seen = 1;
        end
        chk(!seen, {tag, " no take"}, int'(seen), 0);
    endtask

    task automatic expect_ret(input string tag, input int vec, input int lvl);
        chk(ret_vld && int'(ret_vec) == vec, {tag, " ret_vec"},
            ret_vld ? int'(ret_vec) : -1, vec);
        chk(int'(lvl_rd) == lvl, {tag, " restored level"}, int'(lvl_rd), lvl);
    endtask

    // R1
    task automatic t_reset_state();
        do_reset();
        chk(lvl_rd == 0, "R1 level", int'(lvl_rd), 0);
        chk(!take_vld && !ret_vld, "R1 pulses idle", int'({take_vld, ret_vld}), 0);
        expect_quiet("R1", 4);
    endtask

    // R2, R3: exact two-edge latency
    task automatic t_single();
        do_reset();
        set_prio(3, 5);
        @(negedge clk); irq[3] = 1'b1;
        @(negedge clk);
        chk(!take_vld, "R2 not yet after first edge", int'(take_vld), 0);
        @(negedge clk);
        chk(take_vld && take_vec == 3, "R2 take after second edge", int'(take_vec), 3);
        chk(lvl_rd == 6, "R3 level prio+1", int'(lvl_rd), 6);
        @(negedge clk);
        chk(!take_vld, "R2 single-cycle pulse", int'(take_vld), 0);
    endtask

    // R4
    task automatic t_arbitration();
        do_reset();
        set_prio(1, 3); set_prio(6, 9); set_prio(9, 9); set_prio(12, 4);
        @(negedge clk); irq[1] = 1; irq[6] = 1; irq[9] = 1; irq[12] = 1;
        expect_take("R4 highest, tie lowest index", 6, 10);
        do_ret();
        expect_ret("R4 unwind 6", 6, 0);
        expect_take("R4 second of tie", 9, 10);
        do_ret();
        expect_take("R4 next priority", 12, 5);
        do_ret();
        expect_take("R4 lowest priority", 1, 4);
    endtask

    // R5
    task automatic t_held();
        do_reset();
        do_write(8);
        set_prio(2, 3);
        raise(2);
        expect_quiet("R5 masked request", 6);
        chk(lvl_rd == 8, "R5 level held", int'(lvl_rd), 8);
        do_write(3);
        expect_take("R5 taken after level lowered", 2, 4);
    endtask

    // R6, R7
    task automatic t_saturate();
        do_reset();
        set_prio(0, 15); set_prio(1, 15); set_prio(2, 0);
        raise(0);
        expect_take("R6 top priority", 0, 16);
        raise(1); raise(2);
        expect_quiet("R6 all masked at 16", 8);
        chk(lvl_rd == 16, "R6 level stays 16", int'(lvl_rd), 16);
        pulse_exc();
        expect_take("R7 exception while masked", 16, 16);
        do_ret();
        expect_ret("R7 exception unwind", 16, 16);
        do_ret();
        expect_ret("R8 unwind line 0", 0, 0);
        expect_take("R6 pending survives saturation", 1, 16);
    endtask

    // R7: exception outranks a line in the same cycle
    task automatic t_exception();
        do_reset();
        set_prio(5, 12);
        @(negedge clk); irq[5] = 1; exc_req = 1;
        @(negedge clk); exc_req = 0;
        @(negedge clk);
        chk(take_vld && take_vec == 16, "R7 exception first", int'(take_vec), 16);
        chk(lvl_rd == 0, "R7 level unchanged", int'(lvl_rd), 0);
        expect_take("R7 line after exception", 5, 13);
    endtask

    // R8
    task automatic t_nesting();
        do_reset();
        set_prio(4, 2); set_prio(5, 7);
        raise(4);
        expect_take("R8 outer", 4, 3);
        raise(5);
        expect_take("R8 inner", 5, 8);
        do_ret();
        expect_ret("R8 inner return", 5, 3);
        do_ret();
        expect_ret("R8 outer return", 4, 0);
    endtask

    // R9
    task automatic t_empty_return();
        do_reset();
        do_write(5);
        do_ret();
        chk(!ret_vld, "R9 empty return ignored", int'(ret_vld), 0);
        chk(lvl_rd == 5, "R9 level unchanged", int'(lvl_rd), 5);
    endtask

    // R10
    task automatic t_sw_write();
        do_reset();
        do_write(20);
        chk(lvl_rd == 20, "R10 readback", int'(lvl_rd), 20);
        set_prio(7, 15);
        raise(7);
        expect_quiet("R10 level 20 masks", 5);
        do_write(0);
        expect_take("R10 release", 7, 16);
        @(negedge clk); ret_pulse = 1; lvl_wr_en = 1; lvl_wr_data = 5'd9;
        @(negedge clk); ret_pulse = 0; lvl_wr_en = 0;
        chk(ret_vld && ret_vec == 7, "R10 pop with write", int'(ret_vec), 7);
        chk(lvl_rd == 9, "R10 write overrides restore", int'(lvl_rd), 9);
    endtask

    // R11
    task automatic t_repend();
        do_reset();
        set_prio(3, 6);
        raise(3);
        expect_take("R11 first service", 3, 7);
        do_ret();
        expect_quiet("R11 held line not retaken", 5);
        drop(3); raise(3);
        expect_take("R11 new edge", 3, 7);
        drop(3); raise(3);
        expect_quiet("R11 re-pended while serviced", 4);
        do_ret();
        expect_take("R11 taken after return", 3, 7);
    endtask

    // R12
    task automatic t_stack_full();
        do_reset();
        for (int i = 0; i < 17; i++) begin
            pulse_exc();
            expect_take("R12 fill", 16, 0);
        end
        pulse_exc();
        expect_quiet("R12 full stack blocks", 6);
        do_ret();
        expect_ret("R12 one pop", 16, 0);
        expect_take("R12 deferred exception", 16, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_single();
        t_arbitration();
        t_held();
        t_saturate();
        t_exception();
        t_nesting();
        t_empty_return();
        t_sw_write();
        t_repend();
        t_stack_full();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule